// File: doc/BRIEF.md
# Programmable Serial Line Transmitter

This block is an asynchronous serial transmitter that a host controls over a small parallel register bus. The host first selects a register by pulsing an address strobe. It then writes a control word that sets the frame shape and drops a byte into a one-entry holding buffer. The block moves the held byte into a shift stage and drives it onto a single serial output. The holding buffer is then free again, so the host can queue the next byte while the current one is still on the line. Consecutive frames follow one another with no idle gap.

The host sets the frame shape at run time:
- word length of 5 to 8 bits;
- parity that is off, even, odd, or stuck at a fixed level;
- a stop interval of one bit, one and a half bits (5-bit words only) or two bits;
- a break control that forces the line low.

An active-low ready pin and a status register tell the host when the holding buffer is free and when the whole transmitter has drained. The bit rate is fixed by a parameter: one bit lasts 16 baud ticks, and one tick lasts `BAUD_DIV` clocks.

Top module: `serial_tx_linectl`

## Requirements
- R1: After reset the serial line is high, `hold_ready_n` is 0, the status register reads 0x60 and the control register reads 0x00.
- R2: The register address is captured from `bus_addr` in the cycle when `bus_as_n` falls, and later changes on `bus_addr` have no effect. Address 0 is the holding buffer (write only, reads 0). Address 1 is the control register (read/write, all 8 bits). Address 2 is status (read only). Address 3 reads 0 and ignores writes. A write happens in each cycle with `bus_cs`=1 and `bus_wr_n`=0. `bus_rdata` is 0 unless `bus_cs`=1 and `bus_rd_n`=0.
- R3: A frame has a low start bit, then the data bits LSB first, then the stop interval high. The line idles high. Every start, data and parity bit lasts 16*BAUD_DIV clocks.
- R4: Control bits [1:0] give a word length of 5 plus their value. Only that many low bits of the byte are sent.
- R5: Control bit 3 enables a parity bit after the data. With bit 5 clear, control bit 4 = 1 selects even parity (total count of ones, parity included, is even) and bit 4 = 0 selects odd parity.
- R6: With control bit 5 set (and bit 3 set), the parity bit is fixed: 0 when bit 4 = 1 and 1 when bit 4 = 0.
- R7: Control bit 2 = 0 gives a stop interval of 16 ticks. Bit 2 = 1 gives 24 ticks for 5-bit words and 32 ticks for 6 to 8-bit words.
- R8: `hold_ready_n` is 0 whenever the holding buffer is free. A byte written while another frame is shifting starts exactly when the previous stop interval ends.
- R9: A write to address 0 while the holding buffer is full is dropped.
- R10: Status bit 6 reads 1 only when both the holding buffer and the shift stage are empty. Status bit 5 reads 1 when the holding buffer is free. Other status bits read 0.
- R11: While control bit 6 is set, the serial line is low whatever the shift stage is doing. Clearing it returns the line to normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_cs | input | 1 | Bus select, active high |
| bus_as_n | input | 1 | Address strobe, active low; address captured on its falling edge |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| tx_line | output | 1 | Serial output |
| hold_ready_n | output | 1 | Low while the holding buffer can take a byte |

## Verification
Some properties are checked on every cycle:
- the line idles high when nothing is shifting and break is clear;
- break always pulls the line low;
- a frame always opens with the line low;
- the line changes level mid-frame only on a baud tick;
- an accepted byte marks the buffer full;
- the shift stage takes a byte only from a full buffer.

Other behaviour only the bench scenarios can show:
- bit values and bit order;
- parity value for each mode;
- the exact stop lengths, measured as the start-to-start distance of back-to-back frames;
- the dropping of an overflow byte;
- the status readings.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;

    localparam int DATA_W        = 8;
    localparam int ADDR_W        = 2;
    localparam int TICKS_PER_BIT = 16;
    localparam int TCNT_W        = 6;
    localparam int STAT_FREE     = 5;
    localparam int STAT_EMPTY    = 6;

    typedef enum logic [ADDR_W-1:0] {
        A_HOLD = 2'd0,
        A_CTRL = 2'd1,
        A_STAT = 2'd2,
        A_NONE = 2'd3
    } reg_addr_e;

    // control word, MSB first
    typedef struct packed {
        logic       spare;
        logic       brk;
        logic       stick;
        logic       even;
        logic       par_en;
        logic       stop_long;
        logic [1:0] len;
    } ctrl_t;

    // fields captured per frame
    typedef struct packed {
        logic       stick;
        logic       even;
        logic       par_en;
        logic       stop_long;
        logic [1:0] len;
    } frame_cfg_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP
    } tx_state_e;

    function automatic frame_cfg_t cfg_of(ctrl_t c);
        frame_cfg_t f;
        f.stick     = c.stick;
        f.even      = c.even;
        f.par_en    = c.par_en;
        f.stop_long = c.stop_long;
        f.len       = c.len;
        return f;
    endfunction

    function automatic logic [3:0] word_bits(logic [1:0] len);
        return 4'd5 + {2'b00, len};
    endfunction

    function automatic logic [DATA_W-1:0] word_mask(logic [1:0] len);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < DATA_W; i++) begin
            m[i] = (i < int'(word_bits(len)));
        end
        return m;
    endfunction

    function automatic logic parity_of(frame_cfg_t f, logic [DATA_W-1:0] d);
        logic [DATA_W-1:0] m;
        m = d & word_mask(f.len);
        if (f.stick) begin
            return ~f.even;
        end
        return f.even ? (^m) : ~(^m);
    endfunction

    function automatic logic [TCNT_W-1:0] stop_len(frame_cfg_t f);
        if (!f.stop_long) begin
            return TCNT_W'(TICKS_PER_BIT);
        end
        if (f.len == 2'b00) begin
            return TCNT_W'(TICKS_PER_BIT + TICKS_PER_BIT / 2);
        end
        return TCNT_W'(2 * TICKS_PER_BIT);
    endfunction

endpackage

// File: rtl/serial_tx_baud.sv
module serial_tx_baud #(
    parameter int BAUD_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (BAUD_DIV > 1) ? $clog2(BAUD_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(BAUD_DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);
endmodule

// File: rtl/serial_tx_regs.sv
module serial_tx_regs
    import serial_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_cs,
    input  logic              bus_as_n,
    input  logic              bus_wr_n,
    input  logic              bus_rd_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              hold_take,
    input  logic              busy,
    output ctrl_t             ctrl_q,
    output logic [DATA_W-1:0] hold_data,
    output logic              hold_full,
    output logic              hold_we,
    output logic [DATA_W-1:0] bus_rdata
);
    logic      as_prev;
    reg_addr_e addr_q;
    logic      wr_act;
    logic      ctrl_we;
    logic [DATA_W-1:0] stat_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            as_prev <= 1'b1;
            addr_q  <= A_HOLD;
        end else begin
            as_prev <= bus_as_n;
            if (as_prev && !bus_as_n) begin
                addr_q <= reg_addr_e'(bus_addr);
            end
        end
    end

    assign wr_act  = bus_cs && !bus_wr_n;
    assign hold_we = wr_act && (addr_q == A_HOLD) && !hold_full;
    assign ctrl_we = wr_act && (addr_q == A_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            hold_data <= '0;
            hold_full <= 1'b0;
        end else begin
            if (ctrl_we) begin
                ctrl_q <= ctrl_t'(bus_wdata);
            end
            if (hold_we) begin
                hold_data <= bus_wdata;
                hold_full <= 1'b1;
            end else if (hold_take) begin
                hold_full <= 1'b0;
            end
        end
    end

    always_comb begin
        stat_word             = '0;
        stat_word[STAT_FREE]  = !hold_full;
        stat_word[STAT_EMPTY] = !hold_full && !busy;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_cs && !bus_rd_n) begin
            unique case (addr_q)
                A_CTRL:  bus_rdata = ctrl_q;
                A_STAT:  bus_rdata = stat_word;
                default: bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/serial_tx_shifter.sv
module serial_tx_shifter
    import serial_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    input  frame_cfg_t        cfg_in,
    input  logic              brk,
    output logic              hold_take,
    output logic              busy,
    output logic              tx_line
);
    tx_state_e         state;
    frame_cfg_t        cfg;
    logic [DATA_W-1:0] shreg;
    logic              par_q;
    logic [2:0]        bit_idx;
    logic [TCNT_W-1:0] tcnt;
    logic [TCNT_W-1:0] lim;
    logic              line_q;
    logic              bit_end;
    logic              last_data;

    assign lim       = (state == S_STOP) ? stop_len(cfg) : TCNT_W'(TICKS_PER_BIT);
    assign bit_end   = tick && (tcnt == lim - 1'b1);
    assign last_data = ({1'b0, bit_idx} == word_bits(cfg.len) - 4'd1);
    assign hold_take = hold_full && ((state == S_IDLE) || ((state == S_STOP) && bit_end));
    assign busy      = (state != S_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            cfg     <= '0;
            shreg   <= '0;
            par_q   <= 1'b0;
            bit_idx <= '0;
            tcnt    <= '0;
            line_q  <= 1'b1;
        end else if (hold_take) begin
            state   <= S_START;
            cfg     <= cfg_in;
            shreg   <= hold_data;
            par_q   <= parity_of(cfg_in, hold_data);
            bit_idx <= '0;
            tcnt    <= '0;
            line_q  <= 1'b0;
        end else if (tick && busy) begin
            if (!bit_end) begin
                tcnt <= tcnt + 1'b1;
            end else begin
                tcnt <= '0;
                unique case (state)
                    S_START: begin
                        state   <= S_DATA;
                        line_q  <= shreg[0];
                        shreg   <= shreg >> 1;
                        bit_idx <= '0;
                    end
                    S_DATA: begin
                        if (last_data) begin
                            state  <= cfg.par_en ? S_PAR : S_STOP;
                            line_q <= cfg.par_en ? par_q : 1'b1;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                            line_q  <= shreg[0];
                            shreg   <= shreg >> 1;
                        end
                    end
                    S_PAR: begin
                        state  <= S_STOP;
                        line_q <= 1'b1;
                    end
                    default: begin
                        state  <= S_IDLE;
                        line_q <= 1'b1;
                    end
                endcase
            end
        end
    end

    assign tx_line = line_q && !brk;
endmodule

// File: rtl/serial_tx_linectl.sv
module serial_tx_linectl
    import serial_tx_pkg::*;
#(
    parameter int BAUD_DIV = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_cs,
    input  logic              bus_as_n,
    input  logic              bus_wr_n,
    input  logic              bus_rd_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              tx_line,
    output logic              hold_ready_n
);
    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] hold_data;
    logic              hold_full;
    logic              hold_we;
    logic              hold_take;
    logic              sh_busy;
    logic              baud_tick;

    serial_tx_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_cs    (bus_cs),
        .bus_as_n  (bus_as_n),
        .bus_wr_n  (bus_wr_n),
        .bus_rd_n  (bus_rd_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .hold_take (hold_take),
        .busy      (sh_busy),
        .ctrl_q    (ctrl_q),
        .hold_data (hold_data),
        .hold_full (hold_full),
        .hold_we   (hold_we),
        .bus_rdata (bus_rdata)
    );

    serial_tx_baud #(.BAUD_DIV(BAUD_DIV)) u_baud (
        .clk  (clk),
        .rst  (rst),
        .run  (sh_busy),
        .tick (baud_tick)
    );

    serial_tx_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .tick      (baud_tick),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .cfg_in    (cfg_of(ctrl_q)),
        .brk       (ctrl_q.brk),
        .hold_take (hold_take),
        .busy      (sh_busy),
        .tx_line   (tx_line)
    );

    assign hold_ready_n = hold_full;
endmodule

// File: rtl/serial_tx_linectl_chk.sv
module serial_tx_linectl_chk (
    input logic clk,
    input logic rst,
    input logic tx_line,
    input logic hold_ready_n,
    input logic busy,
    input logic hold_full,
    input logic brk,
    input logic tick,
    input logic hold_we,
    input logic hold_take
);
    p_idle_high_r3: assert property (@(posedge clk) disable iff (rst)
        (!busy && !brk) |-> tx_line);

    p_start_low_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !tx_line);

    p_edge_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !brk && !$past(brk) && (tx_line != $past(tx_line)))
        |-> $past(tick));

    p_break_low_r11: assert property (@(posedge clk) disable iff (rst)
        brk |-> !tx_line);

    p_accept_fills_r8: assert property (@(posedge clk) disable iff (rst)
        hold_we |=> hold_ready_n);

    p_take_from_full_r9: assert property (@(posedge clk) disable iff (rst)
        hold_take |-> (hold_full && hold_ready_n && !hold_we));
endmodule

bind serial_tx_linectl serial_tx_linectl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .tx_line      (tx_line),
    .hold_ready_n (hold_ready_n),
    .busy         (sh_busy),
    .hold_full    (hold_full),
    .brk          (ctrl_q.brk),
    .tick         (baud_tick),
    .hold_we      (hold_we),
    .hold_take    (hold_take)
);

// File: tb/serial_tx_linectl_tb.sv
module serial_tx_linectl_tb;
    localparam int DIV = 4;
    localparam int BIT = 16 * DIV;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_cs = 1'b0, bus_as_n = 1'b1, bus_wr_n = 1'b1, bus_rd_n = 1'b1;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       tx_line, hold_ready_n;

    int n_chk = 0;
    int n_fail = 0;
    longint cyc = 0;
    bit done = 0;

    serial_tx_linectl #(.BAUD_DIV(DIV)) u_dut (
        .clk(clk), .rst(rst), .bus_cs(bus_cs), .bus_as_n(bus_as_n),
        .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_line(tx_line), .hold_ready_n(hold_ready_n)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    function automatic int exp_len(input logic [7:0] c);
        return 5 + int'(c[1:0]);
    endfunction

    function automatic logic exp_par(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] m;
        m = d & 8'((1 << exp_len(c)) - 1);
        if (c[5]) return !c[4];
        return c[4] ? ^m : ~^m;
    endfunction

    function automatic longint exp_frame(input logic [7:0] c);
        int st;
        st = !c[2] ? 16 : (c[1:0] == 2'b00 ? 24 : 32);
        return longint'((16 * (1 + exp_len(c) + int'(c[3])) + st) * DIV);
    endfunction

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_cs = 1; bus_as_n = 0; bus_addr = a;
        @(negedge clk);
        bus_addr = ~a; bus_wr_n = 0; bus_wdata = d;
        @(negedge clk);
        bus_wr_n = 1; bus_as_n = 1; bus_cs = 0; bus_addr = '0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_cs = 1; bus_as_n = 0; bus_addr = a;
        @(negedge clk);
        bus_addr = ~a; bus_rd_n = 0;
        @(negedge clk);
        d = bus_rdata;
        bus_rd_n = 1; bus_as_n = 1; bus_cs = 0; bus_addr = '0;
    endtask

    // receiver results
    logic [7:0] rx_d [2];
    logic       rx_p [2];
    logic       rx_s [2];
    logic       rx_st[2];
    longint     rx_t [2];

    task automatic rx_frame(input int k, input logic [7:0] c);
        int w;
        w = 0;
        while (tx_line !== 1'b0 && w < 5000) begin
            @(negedge clk);
            w++;
        end
        rx_t[k] = cyc;
        repeat (BIT / 2) @(negedge clk);
        rx_st[k] = tx_line;
        rx_d[k] = '0;
        for (int i = 0; i < exp_len(c); i++) begin
            repeat (BIT) @(negedge clk);
            rx_d[k][i] = tx_line;
        end
        rx_p[k] = 1'b0;
        if (c[3]) begin
            repeat (BIT) @(negedge clk);
            rx_p[k] = tx_line;
        end
        repeat (BIT) @(negedge clk);
        rx_s[k] = tx_line;
    endtask

    task automatic wait_empty();
        logic [7:0] s;
        int t;
        t = 0;
        s = 0;
        while (!s[6] && t < 3000) begin
            bus_read(2'd2, s);
            t++;
        end
        chk(s == 8'h60, "R10 status when drained", s, 8'h60);
        chk(hold_ready_n == 0, "R8 ready when drained", hold_ready_n, 0);
        chk(tx_line == 1, "R3 idle line high", tx_line, 1);
    endtask

    task automatic run_pair(input logic [7:0] c, input logic [7:0] d0,
                            input logic [7:0] d1, input bit overflow);
        logic [7:0] m, s;
        m = 8'((1 << exp_len(c)) - 1);
        bus_write(2'd1, c);
        fork
            begin
                bus_write(2'd0, d0);
                @(negedge clk);
                while (hold_ready_n) @(negedge clk);
                bus_write(2'd0, d1);
                chk(hold_ready_n == 1, "R8 ready high while buffer full", hold_ready_n, 1);
                bus_read(2'd2, s);
                chk(s == 8'h00, "R10 status mid-frame with buffer full", s, 0);
                if (overflow) bus_write(2'd0, ~d1);
            end
            begin
                rx_frame(0, c);
                rx_frame(1, c);
            end
        join
        for (int k = 0; k < 2; k++) begin
            logic [7:0] d;
            d = (k == 0) ? d0 : d1;
            chk(rx_st[k] == 0, "R3 start bit low", rx_st[k], 0);
            chk(rx_d[k] == (d & m), overflow && k == 1 ? "R9 overflow byte dropped" :
                "R4 data bits LSB first", rx_d[k], d & m);
            if (c[3]) chk(rx_p[k] == exp_par(c, d), c[5] ? "R6 stick parity" : "R5 parity",
                          rx_p[k], exp_par(c, d));
            chk(rx_s[k] == 1, "R3 stop high", rx_s[k], 1);
        end
        chk(rx_t[1] - rx_t[0] == exp_frame(c), "R7 R8 frame spacing / stop length",
            rx_t[1] - rx_t[0], exp_frame(c));
        wait_empty();
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired, actual=running expected=done");
            report();
        end
    end

    initial begin
        logic [7:0] r;
        int seed;
        seed = 32'h5eed1234;
        void'($urandom(seed));
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(tx_line == 1, "R1 line after reset", tx_line, 1);
        chk(hold_ready_n == 0, "R1 ready after reset", hold_ready_n, 0);
        chk(bus_rdata == 0, "R2 rdata idle", bus_rdata, 0);
        bus_read(2'd2, r); chk(r == 8'h60, "R1 status after reset", r, 8'h60);
        bus_read(2'd1, r); chk(r == 8'h00, "R1 control after reset", r, 0);
        // R2 register access with a moving address after the strobe
        bus_write(2'd1, 8'hA7);
        bus_read(2'd1, r); chk(r == 8'hA7, "R2 control readback", r, 8'hA7);
        bus_write(2'd3, 8'hFF);
        bus_read(2'd1, r); chk(r == 8'hA7, "R2 write to address 3 ignored", r, 8'hA7);
        bus_read(2'd3, r); chk(r == 8'h00, "R2 address 3 reads zero", r, 0);
        bus_read(2'd0, r); chk(r == 8'h00, "R2 holding reads zero", r, 0);
        chk(tx_line == 1, "R2 no frame from control write", tx_line, 1);
        // directed corner cases
        run_pair(8'h03, 8'h55, 8'hAA, 0);   // 8N1
        run_pair(8'h08, 8'h55, 8'hAA, 0);   // 5 bits odd
        run_pair(8'h0C, 8'h5A, 8'hA5, 0);   // 5 bits odd, 1.5 stop
        run_pair(8'h38, 8'h55, 8'hAA, 0);   // stick even -> 0
        run_pair(8'h2C, 8'h5A, 8'hA5, 0);   // stick odd -> 1, 1.5 stop
        run_pair(8'h00, 8'h1F, 8'h00, 0);   // 5N1
        run_pair(8'h1F, 8'hC3, 8'h3C, 1);   // 8E2 with overflow write
        run_pair(8'h06, 8'h21, 8'h12, 0);   // 7N2
        // R11 break while idle
        bus_write(2'd1, 8'h40);
        @(negedge clk); chk(tx_line == 0, "R11 break idle forces low", tx_line, 0);
        bus_write(2'd1, 8'h00);
        @(negedge clk); chk(tx_line == 1, "R11 break cleared", tx_line, 1);
        // R11 break during a frame
        bus_write(2'd1, 8'h03);
        bus_write(2'd0, 8'hFF);
        repeat (BIT * 2) @(negedge clk);
        bus_write(2'd1, 8'h43);
        for (int i = 0; i < 4; i++) begin
            repeat (BIT / 2) @(negedge clk);
            chk(tx_line == 0, "R11 break mid-frame forces low", tx_line, 0);
        end
        bus_write(2'd1, 8'h03);
        wait_empty();
        // random frames
        for (int it = 0; it < 14; it++) begin
            logic [7:0] c;
            c = 8'($urandom()) & 8'h3F;
            run_pair(c, 8'($urandom()), 8'($urandom()), (it % 5) == 2);
        end
        done = 1;
        report();
    end
endmodule